// File: doc/BRIEF.md
# Ethernet Controller Command and Interrupt Register Block

This block is the control-register slice of a small Ethernet controller. It holds the command byte, a 16-bit interrupt enable mask, a 16-bit interrupt status register, a 32-bit receive configuration word and a saturating count of frames that were lost for lack of buffer space. The host reaches all of them over a byte-wide bus that has an 8-bit address. Wider registers appear as little-endian byte lanes, so byte 0 sits at the base offset. Reads are combinational from the registers. Writes take effect on the clock edge where `bus_wr` is high.

The receive and transmit datapaths report events as single-cycle pulses on `evt_i`. The block stores these pulses in the status register. The host acknowledges a status bit by writing one to it. `irq_o` is high while any status bit is set whose mask bit is also set.

Setting the reset bit in the command byte starts a self-timing software reset. A two-state machine controls it. In `ST_RUN` the block works normally. A command write with the reset bit set moves it to `ST_SRST` (transition *start*). It stays in `ST_SRST` while a down-counter runs (transition *hold*). A fresh reset write while in `ST_SRST` restarts the count (transition *restart*). The machine returns to `ST_RUN` after `RST_CYCLES` cycles (transition *done*). The reset bit reads back as one for the whole time, so software can poll it.

Top module: `nic_ctrl_regs`

## Requirements
- R1: After `rst_n` is deasserted, `irq_o` is 0. The mask, status, receive configuration and missed-frame count all read zero. The command byte reads back only the buffer-empty input in bit 0.
- R2: A command write with bit 4 clear loads the transmit enable from bit 2 and the receive enable from bit 3. Writing 0x00 turns both off. Bit 0 of the command byte reads `rx_buf_empty_i`. Bits 1, 5, 6 and 7 read 0.
- R3: A command write with bit 4 set makes bit 4 read 1 for exactly `RST_CYCLES` (16) cycles, starting in the cycle after the write. Bit 4 then reads 0. The enables, the mask and the status are all zero during that time and when it ends.
- R4: While the reset is running, writes to the mask, status, receive configuration and missed-count registers are ignored. Event pulses are ignored. Command writes without bit 4 are ignored. A command write with bit 4 set restarts the full `RST_CYCLES` count.
- R5: A pulse on `evt_i[k]` sets status bit k. Only bits 0–6 and 13–15 exist, which is mask 0xE07F. Bits 7–12 of both the mask and the status are never set and read 0. The mask is at 0x3C/0x3D and the status is at 0x3E/0x3F.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. Each byte lane acts only on its own 8 bits.
- R7: If an event pulse and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R8: `irq_o` is 1 exactly when at least one bit is set in both the status and the mask. It follows a register change with no extra delay.
- R9: The receive configuration word is at 0x44–0x47. A write to it is stored only if the transmit or receive enable is set. Otherwise the stored value does not change.
- R10: The missed-frame count is at 0x4C–0x4F, and bytes above `MPC_W` bits read 0. It increments on each `rx_missed_i` pulse and saturates at its maximum. A write to any of its four byte addresses sets it to zero. If a write and a pulse arrive in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rx_buf_empty_i | input | 1 | Receive buffer empty flag from the datapath |
| evt_i | input | 16 | Single-cycle event pulses, one per status bit |
| rx_missed_i | input | 1 | Single-cycle pulse for each lost frame |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `evt_i` and `rx_missed_i` are pulses sampled on the clock edge. They also assume that at most one byte is written per cycle. The properties for reset length and saturation further assume that the host does not write the affected registers while the condition under test is building up. The bench drives every input only on the falling edge and issues one write per task call. During the reset-timing windows it writes only the specific registers it means to show are ignored. The missed-frame count is instantiated at 8 bits, so the bench can drive it into saturation.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    // Byte offsets of the register bases (fixed map)
    localparam logic [7:0] OFS_CMD = 8'h37;
    localparam logic [7:0] OFS_IMR = 8'h3C;
    localparam logic [7:0] OFS_ISR = 8'h3E;
    localparam logic [7:0] OFS_RCR = 8'h44;
    localparam logic [7:0] OFS_MPC = 8'h4C;

    // Command byte bit positions
    localparam int CMD_EMPTY = 0;
    localparam int CMD_TXEN  = 2;
    localparam int CMD_RXEN  = 3;
    localparam int CMD_SRST  = 4;

    // Implemented status / mask bits: 0..6 and 13..15
    localparam logic [15:0] EVT_IMPL = 16'hE07F;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_SRST = 1'b1
    } cmd_state_t;

endpackage

// File: rtl/nic_cmd_fsm.sv
module nic_cmd_fsm
    import nic_regs_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_cmd,
    input  logic [7:0] wdata,
    output logic       srst_start,
    output logic       srst_busy,
    output logic       tx_en,
    output logic       rx_en
);

    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

    cmd_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          rst_req;

    assign rst_req = wr_cmd && wdata[CMD_SRST];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: start, hold, restart, done
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (rst_req) begin
                    state_d = ST_SRST;
                    cnt_d   = '0;
                end
            end
            ST_SRST: begin
                if (rst_req) begin
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        srst_busy  = (state_q == ST_SRST);
        srst_start = rst_req;
    end

    // Enables: loaded only in ST_RUN by a non-reset command write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else if (rst_req || state_q == ST_SRST) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else if (wr_cmd) begin
            tx_en <= wdata[CMD_TXEN];
            rx_en <= wdata[CMD_RXEN];
        end
    end

endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
    import nic_regs_pkg::*;
#(
    parameter int NLANE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_all,
    input  logic [NLANE-1:0]   imr_we,
    input  logic [NLANE-1:0]   isr_we,
    input  logic [7:0]         wdata,
    input  logic [8*NLANE-1:0] evt_i,
    output logic [8*NLANE-1:0] imr_q,
    output logic [8*NLANE-1:0] isr_q,
    output logic               irq_o
);

    localparam int W = 8 * NLANE;

    logic [W-1:0] w1c_mask;
    logic [W-1:0] set_mask;
    logic [W-1:0] imr_d;
    logic [W-1:0] isr_d;

    assign set_mask = clr_all ? '0 : (evt_i & W'(EVT_IMPL));

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign w1c_mask[8*g +: 8] = isr_we[g] ? wdata : 8'h00;
        assign imr_d[8*g +: 8]    = imr_we[g] ? (wdata & EVT_IMPL[8*g +: 8])
                                              : imr_q[8*g +: 8];
    end

    // Event set has priority over write-one-to-clear
    assign isr_d = (isr_q & ~w1c_mask) | set_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr_q <= '0;
            isr_q <= '0;
        end else if (clr_all) begin
            imr_q <= '0;
            isr_q <= '0;
        end else begin
            imr_q <= imr_d;
            isr_q <= isr_d;
        end
    end

    assign irq_o = |(isr_q & imr_q);

endmodule

// File: rtl/nic_rx_cfg.sv
module nic_rx_cfg #(
    parameter int RCR_LANES = 4,
    parameter int MPC_W     = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_open,
    input  logic [RCR_LANES-1:0]   rcr_we,
    input  logic [7:0]             wdata,
    input  logic                   mpc_clr,
    input  logic                   miss_pulse,
    output logic [8*RCR_LANES-1:0] rcr_q,
    output logic [MPC_W-1:0]       mpc_q
);

    localparam logic [MPC_W-1:0] MPC_MAX = '1;

    for (genvar g = 0; g < RCR_LANES; g++) begin : g_rcr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rcr_q[8*g +: 8] <= 8'h00;
            end else if (rcr_we[g] && cfg_open) begin
                rcr_q[8*g +: 8] <= wdata;
            end
        end
    end

    // Saturating missed-frame count; clear beats increment
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mpc_q <= '0;
        end else if (mpc_clr) begin
            mpc_q <= '0;
        end else if (miss_pulse && mpc_q != MPC_MAX) begin
            mpc_q <= mpc_q + 1'b1;
        end
    end

endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
    import nic_regs_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    parameter int MPC_W      = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        rx_buf_empty_i,
    input  logic [15:0] evt_i,
    input  logic        rx_missed_i,
    output logic        irq_o
);

    localparam int IRQ_LANES = 2;
    localparam int RCR_LANES = 4;
    localparam int MPC_LANES = 4;

    logic        wr_cmd;
    logic        srst_start;
    logic        srst_busy;
    logic        tx_en;
    logic        rx_en;
    logic        wr_ok;
    logic [IRQ_LANES-1:0] imr_we;
    logic [IRQ_LANES-1:0] isr_we;
    logic [RCR_LANES-1:0] rcr_we;
    logic [MPC_LANES-1:0] mpc_hit;
    logic        mpc_clr;
    logic [15:0] imr_q;
    logic [15:0] isr_q;
    logic [31:0] rcr_q;
    logic [MPC_W-1:0] mpc_q;
    logic [31:0] mpc_wide;
    logic [7:0]  cmd_rd;

    assign wr_cmd = bus_wr && (bus_addr == OFS_CMD);
    assign wr_ok  = bus_wr && !srst_busy;

    for (genvar g = 0; g < IRQ_LANES; g++) begin : g_irq_dec
        assign imr_we[g] = wr_ok && (bus_addr == OFS_IMR + 8'(g));
        assign isr_we[g] = wr_ok && (bus_addr == OFS_ISR + 8'(g));
    end
    for (genvar g = 0; g < RCR_LANES; g++) begin : g_rcr_dec
        assign rcr_we[g] = wr_ok && (bus_addr == OFS_RCR + 8'(g));
    end
    for (genvar g = 0; g < MPC_LANES; g++) begin : g_mpc_dec
        assign mpc_hit[g] = wr_ok && (bus_addr == OFS_MPC + 8'(g));
    end
    assign mpc_clr = |mpc_hit;

    nic_cmd_fsm #(.RST_CYCLES(RST_CYCLES)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (wr_cmd),
        .wdata      (bus_wdata),
        .srst_start (srst_start),
        .srst_busy  (srst_busy),
        .tx_en      (tx_en),
        .rx_en      (rx_en)
    );

    nic_irq_regs #(.NLANE(IRQ_LANES)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (srst_start || srst_busy),
        .imr_we  (imr_we),
        .isr_we  (isr_we),
        .wdata   (bus_wdata),
        .evt_i   (evt_i),
        .imr_q   (imr_q),
        .isr_q   (isr_q),
        .irq_o   (irq_o)
    );

    nic_rx_cfg #(.RCR_LANES(RCR_LANES), .MPC_W(MPC_W)) u_rxc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_open   (tx_en || rx_en),
        .rcr_we     (rcr_we),
        .wdata      (bus_wdata),
        .mpc_clr    (mpc_clr),
        .miss_pulse (rx_missed_i),
        .rcr_q      (rcr_q),
        .mpc_q      (mpc_q)
    );

    assign mpc_wide = 32'(mpc_q);

    always_comb begin
        cmd_rd            = 8'h00;
        cmd_rd[CMD_EMPTY] = rx_buf_empty_i;
        cmd_rd[CMD_TXEN]  = tx_en;
        cmd_rd[CMD_RXEN]  = rx_en;
        cmd_rd[CMD_SRST]  = srst_busy;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            OFS_CMD:         bus_rdata = cmd_rd;
            OFS_IMR:         bus_rdata = imr_q[7:0];
            OFS_IMR + 8'd1:  bus_rdata = imr_q[15:8];
            OFS_ISR:         bus_rdata = isr_q[7:0];
            OFS_ISR + 8'd1:  bus_rdata = isr_q[15:8];
            OFS_RCR:         bus_rdata = rcr_q[7:0];
            OFS_RCR + 8'd1:  bus_rdata = rcr_q[15:8];
            OFS_RCR + 8'd2:  bus_rdata = rcr_q[23:16];
            OFS_RCR + 8'd3:  bus_rdata = rcr_q[31:24];
            OFS_MPC:         bus_rdata = mpc_wide[7:0];
            OFS_MPC + 8'd1:  bus_rdata = mpc_wide[15:8];
            OFS_MPC + 8'd2:  bus_rdata = mpc_wide[23:16];
            OFS_MPC + 8'd3:  bus_rdata = mpc_wide[31:24];
            default:         bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/nic_ctrl_regs_chk.sv
module nic_ctrl_regs_chk
    import nic_regs_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    parameter int MPC_W      = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [15:0]      evt_i,
    input logic             rx_missed_i,
    input logic             irq_o,
    input logic             srst_busy,
    input logic             tx_en,
    input logic             rx_en,
    input logic [15:0]      imr_q,
    input logic [15:0]      isr_q,
    input logic [31:0]      rcr_q,
    input logic [MPC_W-1:0] mpc_q
);

    localparam logic [MPC_W-1:0] MPC_MAX = '1;

    logic        start_w;
    logic        mpc_wr;
    logic [15:0] busy_cnt;

    assign start_w = bus_wr && bus_addr == OFS_CMD && bus_wdata[CMD_SRST];
    assign mpc_wr  = bus_wr && bus_addr >= OFS_MPC && bus_addr <= OFS_MPC + 8'd3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          busy_cnt <= '0;
        else if (start_w)    busy_cnt <= '0;
        else if (srst_busy)  busy_cnt <= busy_cnt + 16'd1;
        else                 busy_cnt <= '0;
    end

    assert_reset_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_busy) |-> ($past(busy_cnt) == 16'(RST_CYCLES - 1)));

    assert_reset_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (imr_q == 16'h0 && isr_q == 16'h0 && !tx_en && !rx_en));

    assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr_q | imr_q) & ~EVT_IMPL) == 16'h0);

    assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_busy && !start_w && |(evt_i & EVT_IMPL))
        |=> ((isr_q & $past(evt_i & EVT_IMPL)) == $past(evt_i & EVT_IMPL)));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_q & imr_q) == 16'h0 |-> !irq_o);

    assert_irq_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_q & imr_q) != 16'h0 |-> irq_o);

    assert_rcr_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !rx_en) |=> $stable(rcr_q));

    assert_mpc_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mpc_q == MPC_MAX && !mpc_wr) |=> mpc_q == MPC_MAX);

endmodule

bind nic_ctrl_regs nic_ctrl_regs_chk #(.RST_CYCLES(RST_CYCLES), .MPC_W(MPC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .evt_i       (evt_i),
    .rx_missed_i (rx_missed_i),
    .irq_o       (irq_o),
    .srst_busy   (srst_busy),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .imr_q       (imr_q),
    .isr_q       (isr_q),
    .rcr_q       (rcr_q),
    .mpc_q       (mpc_q)
);

// File: tb/tb_nic_ctrl_regs.sv
module tb_nic_ctrl_regs;

    localparam int RST_CYC = 16;
    localparam int MPCW    = 8;
    localparam logic [15:0] IMPL = 16'hE07F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        rx_buf_empty_i = 1'b1;
    logic [15:0] evt_i = 16'h0;
    logic        rx_missed_i = 1'b0;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    nic_ctrl_regs #(.RST_CYCLES(RST_CYC), .MPC_W(MPCW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_buf_empty_i(rx_buf_empty_i), .evt_i(evt_i),
        .rx_missed_i(rx_missed_i), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rd16(input logic [7:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo); rd(a + 8'd1, hi); d = {hi, lo};
    endtask

    task automatic pulse(input logic [15:0] e);
        evt_i = e;
        @(posedge clk); @(negedge clk);
        evt_i = 16'h0;
    endtask

    task automatic wr16(input logic [7:0] a, input logic [15:0] d);
        wr(a, d[7:0]); wr(a + 8'd1, d[15:8]);
    endtask

    task automatic count_busy(output int n);
        logic [7:0] c;
        n = 0;
        rd(8'h37, c);
        while (c[4] && n < 1000) begin
            n++;
            @(negedge clk);
            rd(8'h37, c);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] h;
        logic [31:0] rcr_m;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq_o), 0);
        rd(8'h37, b); check("R1 cmd", 32'(b), 32'h01);
        rd16(8'h3C, h); check("R1 mask", 32'(h), 0);
        rd16(8'h3E, h); check("R1 status", 32'(h), 0);
        for (int i = 0; i < 4; i++) begin
            rd(8'h44 + 8'(i), b); check("R1 rxcfg", 32'(b), 0);
            rd(8'h4C + 8'(i), b); check("R1 missed", 32'(b), 0);
        end

        // R2 command sweep over all values with bit 4 clear
        for (int d = 0; d < 256; d++) begin
            if (d[4] == 1'b0) begin
                rx_buf_empty_i = d[0] ^ d[1];
                wr(8'h37, 8'(d));
                rd(8'h37, b);
                check("R2 cmd", 32'(b), 32'((d & 8'h0C) | (d[0] ^ d[1])));
            end
        end
        rx_buf_empty_i = 1'b1;
        wr(8'h37, 8'h00); rd(8'h37, b); check("R2 off", 32'(b), 32'h01);

        // R9 receive configuration gated by the enables
        rcr_m = 32'h0;
        for (int en = 0; en < 4; en++) begin
            wr(8'h37, 8'(en << 2));
            for (int k = 0; k < 4; k++) begin
                wr(8'h44 + 8'(k), 8'(8'h11 * (en + 1) + k));
                if (en != 0) rcr_m[8*k +: 8] = 8'(8'h11 * (en + 1) + k);
                wr(8'h37, 8'h00);
                rd(8'h44 + 8'(k), b);
                check("R9 rxcfg", 32'(b), 32'(rcr_m[8*k +: 8]));
                wr(8'h37, 8'(en << 2));
            end
        end
        wr(8'h37, 8'h00);
        wr(8'h44, 8'h5A); rd(8'h44, b); check("R9 locked", 32'(b), 32'(rcr_m[7:0]));

        // R5 mask readback and per-bit event sweep
        wr16(8'h3C, 16'hFFFF); rd16(8'h3C, h); check("R5 mask impl", 32'(h), 32'(IMPL));
        for (int k = 0; k < 16; k++) begin
            wr16(8'h3E, 16'hFFFF);
            pulse(16'(1 << k));
            rd16(8'h3E, h);
            check("R5 status bit", 32'(h), 32'(IMPL & 16'(1 << k)));
            check("R8 irq all-mask", 32'(irq_o), 32'(IMPL[k]));
        end

        // R8 mask x event sweep
        for (int m = 0; m < 16; m++) begin
            wr16(8'h3C, 16'(1 << m));
            for (int j = 0; j < 16; j++) begin
                wr16(8'h3E, 16'hFFFF);
                pulse(16'(1 << j));
                check("R8 irq", 32'(irq_o), 32'(m == j && IMPL[j]));
            end
        end

        // R6 write-one-to-clear by lane
        wr16(8'h3E, 16'hFFFF);
        pulse(16'hFFFF);
        wr(8'h3E, 8'h05); rd16(8'h3E, h); check("R6 low lane", 32'(h), 32'hE07A);
        wr(8'h3F, 8'h00); rd16(8'h3E, h); check("R6 zero write", 32'(h), 32'hE07A);
        wr(8'h3F, 8'h20); rd16(8'h3E, h); check("R6 high lane", 32'(h), 32'hC07A);

        // R7 event beats clear in the same cycle
        wr16(8'h3E, 16'hFFFF);
        pulse(16'h0003);
        evt_i = 16'h0001;
        wr(8'h3E, 8'hFF);
        evt_i = 16'h0;
        rd16(8'h3E, h); check("R7 event wins", 32'(h), 32'h0001);

        // R10 missed-frame count
        for (int i = 0; i < 10; i++) begin
            rx_missed_i = 1'b1; @(posedge clk); @(negedge clk);
        end
        rx_missed_i = 1'b0;
        rd(8'h4C, b); check("R10 count", 32'(b), 10);
        wr(8'h4E, 8'h77); rd(8'h4C, b); check("R10 clear", 32'(b), 0);
        rx_missed_i = 1'b1;
        repeat (300) begin @(posedge clk); @(negedge clk); end
        rx_missed_i = 1'b0;
        rd(8'h4C, b); check("R10 saturate", 32'(b), 255);
        rd(8'h4D, b); check("R10 upper byte", 32'(b), 0);
        rx_missed_i = 1'b1;
        wr(8'h4F, 8'h00);
        rx_missed_i = 1'b0;
        rd(8'h4C, b); check("R10 clear wins", 32'(b), 0);

        // R3 software reset timing and clearing
        wr(8'h37, 8'h0C);
        wr16(8'h3C, 16'hFFFF);
        pulse(16'h8001);
        check("R3 irq before", 32'(irq_o), 1);
        wr(8'h37, 8'h1C);
        count_busy(n);
        check("R3 busy cycles", 32'(n), RST_CYC);
        rd(8'h37, b); check("R3 cmd after", 32'(b), 32'h01);
        rd16(8'h3C, h); check("R3 mask after", 32'(h), 0);
        rd16(8'h3E, h); check("R3 status after", 32'(h), 0);
        check("R3 irq after", 32'(irq_o), 0);

        // R4 writes and events during reset are ignored
        rx_missed_i = 1'b1; repeat (3) begin @(posedge clk); @(negedge clk); end
        rx_missed_i = 1'b0;
        wr(8'h37, 8'h10);
        wr(8'h3C, 8'hFF);
        wr(8'h4C, 8'h00);
        wr(8'h37, 8'h0C);
        pulse(16'h0004);
        wr(8'h44, 8'hEE);
        count_busy(n);
        check("R4 busy cycles", 32'(n), RST_CYC - 5);
        rd16(8'h3C, h); check("R4 mask ignored", 32'(h), 0);
        rd(8'h4C, b); check("R4 missed ignored", 32'(b), 3);
        rd(8'h37, b); check("R4 cmd ignored", 32'(b), 32'h01);
        rd16(8'h3E, h); check("R4 event ignored", 32'(h), 0);
        rd(8'h44, b); check("R4 rxcfg ignored", 32'(b), 32'(rcr_m[7:0]));

        // R4 restart of the reset count
        wr(8'h37, 8'h10);
        repeat (4) @(negedge clk);
        wr(8'h37, 8'h10);
        count_busy(n);
        check("R4 restart cycles", 32'(n), RST_CYC);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule